// File: doc/BRIEF.md
# Smart Card Character Convention Codec

This block turns a parallel byte into the 10-bit character used on a smart card I/O line, and turns such a character back into a byte. A character is a start bit, eight data bits and a parity bit. The line is high (state Z) when idle. The start bit is low (state A).

Three static controls set the convention:
- `msb_first` chooses the order of the data bits.
- `invert_data` inverts the levels of the eight data bits only.
- `parity_odd` chooses even or odd parity. Parity is counted over the data bits as they appear on the line.

Direct convention uses all three controls at 0. Inverse convention uses all three at 1. With these settings the card's opening character reads 0x3B in direct convention and 0x3F in inverse convention.

The transmitter accepts a byte through a valid/ready handshake and moves one bit per `tick` pulse. The `tick` pulse marks one elementary time unit and comes from outside the block. The receiver waits for a falling edge on the line and samples on `tick`. It then delivers the byte with a one-cycle strobe and a parity error flag.

Top module: `sc_char_codec`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_busy` is 0, `tx_ready` is 1 and `rx_valid` is 0. Whenever the transmitter is not busy, `tx_line` is 1.
- R2: When a byte is accepted, `tx_line` drives the start bit (0) from the next cycle. Each following `tick` moves to the next bit: data bit 1 through data bit 8, then the parity bit. The line changes only on a `tick`.
- R3: With `msb_first`=0 the data bits go out as D0 first and D7 last. With `msb_first`=1 they go out as D7 first and D0 last. The receiver uses the same ordering.
- R4: With `invert_data`=1 each data bit is sent as its complement, and the receiver complements it back. The parity bit is never inverted.
- R5: The parity bit on the line is the XOR of the eight data bits as they appear on the line, XORed with `parity_odd`. So the number of ones across the line data bits and the parity bit is even when `parity_odd`=0 and odd when `parity_odd`=1.
- R6: A byte is accepted only when `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 while busy, and `tx_valid` has no effect on the character in flight.
- R7: `tx_busy` rises in the cycle after acceptance. It falls on the `tick` that ends the parity bit.
- R8: The cycle after the `tick` that samples the parity bit, `rx_valid` is 1 for exactly one cycle. In that same cycle `rx_data` holds the decoded byte.
- R9: `rx_parity_err` is 1 together with `rx_valid` when the received line data bits and parity bit fail the parity rule of R5. Otherwise it is 0.
- R10: A falling edge on `rx_line` arms the receiver. If `rx_line` is already high again at the next `tick`, the receiver returns to idle and produces no `rx_valid`.
- R11: Direct settings (0,0,0) encode byte 0x3B with a parity bit of 1. Inverse settings (1,1,1) encode byte 0x3F with a parity bit of 1 (state Z).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per elementary time unit |
| msb_first | input | 1 | Data bit order: 0 = LSB first, 1 = MSB first |
| invert_data | input | 1 | Invert data bit levels on the line |
| parity_odd | input | 1 | 0 = even parity, 1 = odd parity |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_busy | output | 1 | A character is being sent |
| tx_line | output | 1 | Serial line out, idle high |
| rx_line | input | 1 | Serial line in, idle high |
| rx_valid | output | 1 | One-cycle strobe: received byte ready |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | Parity check failed for this byte |

## Verification
A wrong bit counter shows at the ports within one character. The transmitter would send too few or too many bits or return to idle on the wrong tick, and the receiver would strobe on the wrong tick. A wrong ordering or inversion path shows on the first non-symmetric byte as a reordered or complemented value. Wrong parity polarity shows as a parity bit of the wrong level, or as a false `rx_parity_err`. The bench decodes each transmitted character at the tick boundaries and compares it with an expected frame that it computes itself. It feeds the receiver frames built the same way, including a bad parity bit and a glitch on the line.

// File: rtl/sc_char_codec.sv
module sc_char_codec (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       msb_first,
  input  logic       invert_data,
  input  logic       parity_odd,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       tx_busy,
  output logic       tx_line,
  input  logic       rx_line,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_parity_err
);
  localparam int FRAME_W = 10;
  localparam int LAST_TX = FRAME_W - 1;
  localparam int LAST_RX = FRAME_W - 2;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  logic [7:0]         tx_ord, tx_ldata;
  logic               tx_par;
  logic [FRAME_W-1:0] tx_sr;
  logic [3:0]         tx_cnt;

  assign tx_ord   = msb_first ? rev8(tx_data) : tx_data;
  assign tx_ldata = tx_ord ^ {8{invert_data}};
  assign tx_par   = (^tx_ldata) ^ parity_odd;
  assign tx_ready = !tx_busy;
  assign tx_line  = tx_busy ? tx_sr[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '1;
      tx_cnt  <= '0;
      tx_busy <= 1'b0;
    end else if (!tx_busy) begin
      if (tx_valid) begin
        tx_sr   <= {tx_par, tx_ldata, 1'b0};
        tx_cnt  <= '0;
        tx_busy <= 1'b1;
      end
    end else if (tick) begin
      tx_sr <= {1'b1, tx_sr[FRAME_W-1:1]};
      if (tx_cnt == 4'(LAST_TX)) begin
        tx_busy <= 1'b0;
        tx_cnt  <= '0;
      end else begin
        tx_cnt <= tx_cnt + 4'd1;
      end
    end
  end

  typedef enum logic [1:0] {RX_IDLE, RX_ARMED, RX_BITS} rx_state_t;
  rx_state_t  rx_st;
  logic       rx_prev;
  logic [3:0] rx_cnt;
  logic [7:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_st         <= RX_IDLE;
      rx_prev       <= 1'b1;
      rx_cnt        <= '0;
      rx_sr         <= '0;
      rx_valid      <= 1'b0;
      rx_data       <= '0;
      rx_parity_err <= 1'b0;
    end else begin
      rx_prev       <= rx_line;
      rx_valid      <= 1'b0;
      rx_parity_err <= 1'b0;
      case (rx_st)
        RX_IDLE:  if (rx_prev && !rx_line) rx_st <= RX_ARMED;
        RX_ARMED: if (tick) begin
          rx_cnt <= '0;
          rx_st  <= rx_line ? RX_IDLE : RX_BITS;
        end
        RX_BITS:  if (tick) begin
          if (rx_cnt == 4'(LAST_RX)) begin
            rx_valid      <= 1'b1;
            rx_data       <= (msb_first ? rev8(rx_sr) : rx_sr) ^ {8{invert_data}};
            rx_parity_err <= ((^rx_sr) ^ rx_line) != parity_odd;
            rx_st         <= RX_IDLE;
          end else begin
            rx_sr  <= {rx_line, rx_sr[7:1]};
            rx_cnt <= rx_cnt + 4'd1;
          end
        end
        default:  rx_st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_char_codec_chk.sv
module sc_char_codec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_busy,
  input logic       tx_line,
  input logic       rx_valid
);
  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (tx_busy && !tx_line));
  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tick) |=> $stable(tx_line));
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(tick));
  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);
  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R8
  rx_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(tick));
endmodule

bind sc_char_codec sc_char_codec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_busy(tx_busy), .tx_line(tx_line), .rx_valid(rx_valid)
);

// File: tb/sim_sc_char_codec.sv
`timescale 1ns/1ps
module sim_sc_char_codec;
  localparam int CLK_P = 10;
  localparam int ETU   = 8;

  logic clk = 0, rst_n = 0;
  logic msb_first = 0, invert_data = 0, parity_odd = 0;
  logic tx_valid = 0, rx_line = 1;
  logic [7:0] tx_data = 0;
  logic tx_ready, tx_busy, tx_line, rx_valid, rx_parity_err, tick;
  logic [7:0] rx_data;
  logic [3:0] tcnt = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) tcnt <= (tcnt == 4'(ETU-1)) ? 4'd0 : tcnt + 4'd1;
  assign tick = (tcnt == 4'(ETU-1));

  sc_char_codec u0 (.*);

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [9:0] frame(input logic [7:0] d, input logic m, input logic i, input logic o);
    logic [7:0] l;
    for (int k = 0; k < 8; k++) l[k] = (m ? d[7-k] : d[k]) ^ i;
    return {(^l) ^ o, l, 1'b0};
  endfunction

  task automatic tx_case(input logic [7:0] d, input logic m, input logic i, input logic o,
                         input bit junk, input string tag);
    logic [9:0] got;
    int k;
    msb_first = m; invert_data = i; parity_odd = o;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1;
    @(negedge clk);
    tx_valid = junk; tx_data = ~d;
    check(tx_busy, 1, {tag, " R7 busy after accept"});
    if (junk) check(tx_ready, 0, {tag, " R6 ready low while busy"});
    k = 0;
    while (k < 10) begin
      if (tick) begin
        got[k] = tx_line;
        k++;
        if (k == 10) tx_valid = 0;
      end
      @(negedge clk);
    end
    check(got, frame(d, m, i, o), {tag, " R2 R3 R4 R5 frame"});
    check({tx_busy, tx_line}, 2'b01, {tag, " R7 R1 idle after parity"});
  endtask

  task automatic rx_send(input logic [9:0] f);
    for (int k = 0; k < 10; k++) begin
      rx_line = f[k];
      @(negedge clk);
      while (!tick) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic rx_case(input logic [7:0] d, input logic m, input logic i, input logic o,
                         input bit bad_par, input string tag);
    logic [9:0] f;
    msb_first = m; invert_data = i; parity_odd = o;
    f = frame(d, m, i, o);
    if (bad_par) f[9] = ~f[9];
    rx_line = 1;
    repeat (3) @(negedge clk);
    rx_send(f);
    check(rx_valid, 1, {tag, " R8 valid strobe"});
    check(rx_data, d, {tag, " R3 R4 R8 data"});
    check(rx_parity_err, bad_par, {tag, " R9 parity flag"});
    rx_line = 1;
    @(negedge clk);
    check(rx_valid, 0, {tag, " R8 single cycle"});
  endtask

  task automatic rx_glitch();
    int seen = 0;
    rx_line = 1;
    @(negedge clk);
    while (!tick) @(negedge clk);
    @(negedge clk);
    rx_line = 0;
    repeat (2) @(negedge clk);
    rx_line = 1;
    repeat (12 * ETU) begin
      @(negedge clk);
      if (rx_valid) seen++;
    end
    check(seen, 0, "R10 false start ignored");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({tx_line, tx_busy, tx_ready, rx_valid}, 4'b1010, "R1 reset state");
    rst_n = 1;
    @(negedge clk);
    check({tx_line, tx_busy, tx_ready, rx_valid}, 4'b1010, "R1 after reset release");

    tx_case(8'h3B, 0, 0, 0, 0, "R11 direct 3B");
    tx_case(8'h3F, 1, 1, 1, 0, "R11 inverse 3F");
    check(frame(8'h3B, 0, 0, 0) >> 9, 1, "R11 direct parity level");
    check(frame(8'h3F, 1, 1, 1) >> 9, 1, "R11 inverse parity level");
    tx_case(8'hA6, 1, 0, 0, 0, "R3 msb first");
    tx_case(8'h96, 0, 1, 1, 0, "R4 inverted odd");
    tx_case(8'h01, 0, 0, 1, 1, "R6 ignore valid while busy");

    rx_case(8'h3B, 0, 0, 0, 0, "R11 rx direct");
    rx_case(8'h3F, 1, 1, 1, 0, "R11 rx inverse");
    rx_case(8'hC5, 1, 0, 0, 0, "R3 rx msb first");
    rx_case(8'h5A, 0, 1, 0, 0, "R4 rx inverted");
    rx_case(8'h77, 0, 0, 1, 1, "R9 rx bad parity");
    rx_glitch();
    rx_case(8'h12, 0, 0, 0, 0, "R10 rx after glitch");

    finish_run();
  end
endmodule